// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM core. Commands are sampled on the rising clock edge: an address, an active-low select, an active-low global write enable and one active-low write enable per 9-bit byte lane. Read data comes out through an output register. A write is "late": its data arrives on the edge after its address. That data is held in a write buffer and reaches the array only when the next write executes. A read that hits the buffered address gets the enabled lanes from the buffer, laid over the array word.

Outputs are a data-out bus plus a separate output-enable flag in place of a tri-state pin. An asynchronous active-low output enable and an asynchronous sleep input both force the flag low. While sleep is high, commands and write data are ignored. The array has 2^AW words, so it can be kept small for simulation.

Top module: `lw_sram`

## Requirements
- R1: After reset, dOe is 0 and dOut is all zeros.
- R2: A read sampled at edge n (selN=0, wrN=1) updates dOut at edge n+1. dOe is then 1 while outEnN=0 and sleep=0.
- R3: The write data for a write sampled at edge n is taken from dIn at edge n+1. Later reads of that address return it.
- R4: Lane i covers dIn/dOut bits [9i+8:9i] and is written only when laneWrN[i]=0 and wrN=0. Disabled lanes keep their old contents.
- R5: A write with all four laneWrN bits high is an abort. The array and buffer are unchanged, the data on the following edge is ignored, and dOe is 0 for that cycle.
- R6: A deselect (selN=1) at edge n gives dOe=0 after edge n+1.
- R7: A read of the address held in the write buffer returns the buffered enabled lanes merged over the array word. This includes a read issued right after the write.
- R8: The buffered write is retired into the array, with its saved address and lane mask, when the next write executes.
- R9: outEnN=1 forces dOe to 0 at once, regardless of clocked state.
- R10: While sleep=1, dOe is 0 at once, and commands and write data sampled then have no effect.
- R11: A write cycle (selN=0, wrN=0) gives dOe=0 after the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| selN | input | 1 | Synchronous select, active low |
| wrN | input | 1 | Global write enable, active low |
| laneWrN | input | LANES | Per-lane write enables, active low |
| dIn | input | LANES*LW | Write data, one cycle after its address |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dOut | output | LANES*LW | Registered read data |
| dOe | output | 1 | Data-out valid/drive flag (0 means high-impedance) |

## Verification
The hardest state to reach from the ports is a forwarded read whose result mixes lanes. The buffer has to hold a partial-lane write to an address that already holds a different full word in the array, and the read has to land before the next write retires the buffer. The stimulus table does this in order: a full write, then a read, then a single-lane write to the same address with all-ones data, then a read issued on the very next edge. The expected word has one lane changed and three lanes unchanged. Later rows push that buffer into the array with a write to another address, and read the merged word back from the array.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  // strobes from control to datapath for the operation in the execute stage
  typedef struct packed {
    logic rdFire;   // load output register from array/buffer
    logic wrFire;   // capture write data, retire previous buffer
  } strobe_t;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             selN,
  input  logic             wrN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             sleep,
  output strobe_t          stb,
  output logic [AW-1:0]    opAddr,
  output logic [LANES-1:0] opMask,
  output logic             outValid
);
  logic             s1Rd, s1Wr;
  logic [AW-1:0]    s1Addr;
  logic [LANES-1:0] s1Mask;
  logic             take;
  logic             anyLane;

  assign take    = !sleep && !selN;
  assign anyLane = |(~laneWrN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Rd     <= 1'b0;
      s1Wr     <= 1'b0;
      s1Addr   <= '0;
      s1Mask   <= '0;
      outValid <= 1'b0;
    end else begin
      s1Rd     <= take && wrN;
      s1Wr     <= take && !wrN && anyLane;  // abort cycles never reach execute
      s1Addr   <= addr;
      s1Mask   <= ~laneWrN;
      outValid <= s1Rd;
    end
  end

  always_comb begin
    stb.rdFire = s1Rd;
    stb.wrFire = s1Wr && !sleep;  // data edge during sleep is ignored
  end

  assign opAddr = s1Addr;
  assign opMask = s1Mask;
endmodule

// File: rtl/lw_sram_dp.sv
module lw_sram_dp
  import lw_sram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [AW-1:0]       opAddr,
  input  logic [LANES-1:0]    opMask,
  input  logic [LANES*LW-1:0] dIn,
  output logic [LANES*LW-1:0] dOut
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             bufValid;
  logic [AW-1:0]    bufAddr;
  logic [LANES-1:0] bufMask;
  logic [DW-1:0]    bufData;
  logic [DW-1:0]    rdWord;
  logic [DW-1:0]    outQ;
  logic             hit;

  assign hit = bufValid && (bufAddr == opAddr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rdWord[i*LW +: LW] = (hit && bufMask[i]) ? bufData[i*LW +: LW]
                                                    : mem[opAddr][i*LW +: LW];
  end

  // retire pending buffer into the array when the next write executes
  always_ff @(posedge clk) begin
    if (stb.wrFire && bufValid) begin
      for (int i = 0; i < LANES; i++) begin
        if (bufMask[i]) mem[bufAddr][i*LW +: LW] <= bufData[i*LW +: LW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufValid <= 1'b0;
      bufAddr  <= '0;
      bufMask  <= '0;
      bufData  <= '0;
    end else if (stb.wrFire) begin
      bufValid <= 1'b1;
      bufAddr  <= opAddr;
      bufMask  <= opMask;
      bufData  <= dIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outQ <= '0;
    else if (stb.rdFire) outQ <= rdWord;
  end

  assign dOut = outQ;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                selN,
  input  logic                wrN,
  input  logic [LANES-1:0]    laneWrN,
  input  logic [LANES*LW-1:0] dIn,
  input  logic                outEnN,
  input  logic                sleep,
  output logic [LANES*LW-1:0] dOut,
  output logic                dOe
);
  strobe_t          stb;
  logic [AW-1:0]    opAddr;
  logic [LANES-1:0] opMask;
  logic             outValid;

  lw_sram_ctrl #(.AW(AW), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .selN(selN), .wrN(wrN),
    .laneWrN(laneWrN), .sleep(sleep), .stb(stb), .opAddr(opAddr),
    .opMask(opMask), .outValid(outValid)
  );

  lw_sram_dp #(.AW(AW), .LANES(LANES), .LW(LW)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .opAddr(opAddr), .opMask(opMask),
    .dIn(dIn), .dOut(dOut)
  );

  assign dOe = outValid && !outEnN && !sleep;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic selN,
  input logic wrN,
  input logic outEnN,
  input logic sleep,
  input logic dOe
);
  AST_OEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !dOe);  // R9
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dOe);  // R10
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && selN) |=> ##1 !dOe);  // R6
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !selN && !wrN) |=> ##1 !dOe);  // R11
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !selN && wrN) |=> ##1 (dOe || outEnN || sleep));  // R2
endmodule

bind lw_sram lw_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .selN(selN), .wrN(wrN),
  .outEnN(outEnN), .sleep(sleep), .dOe(dOe)
);

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, LANES = 4, LW = 9, DW = LANES * LW;

  typedef struct packed {
    logic          selN;
    logic          wrN;
    logic [3:0]    lanesN;
    logic [3:0]    addr;
    logic [35:0]   din;
    logic          oeN;
    logic          expOe;
    logic [35:0]   expData;
    logic [3:0]    req;
  } vec_t;

  // row k drives the command for edge k; expectation is the state after edge k
  localparam int ROWS = 17;
  localparam vec_t VEC [ROWS] = '{
    '{1'b0, 1'b0, 4'h0, 4'd1, 36'h0,         1'b0, 1'b0, 36'h0,         4'd11}, // R11
    '{1'b0, 1'b0, 4'h0, 4'd2, 36'h123456789, 1'b0, 1'b0, 36'h0,         4'd11}, // R3 data
    '{1'b0, 1'b0, 4'h0, 4'd3, 36'hABCDEF012, 1'b0, 1'b0, 36'h0,         4'd11},
    '{1'b0, 1'b1, 4'hF, 4'd1, 36'h0F0F0F0F0, 1'b0, 1'b0, 36'h0,         4'd11},
    '{1'b0, 1'b1, 4'hF, 4'd2, 36'h0,         1'b0, 1'b1, 36'h123456789, 4'd8},  // R8
    '{1'b0, 1'b1, 4'hF, 4'd3, 36'h0,         1'b0, 1'b1, 36'hABCDEF012, 4'd3},  // R3
    '{1'b0, 1'b0, 4'hE, 4'd3, 36'h0,         1'b0, 1'b1, 36'h0F0F0F0F0, 4'd7},  // R7
    '{1'b0, 1'b1, 4'hF, 4'd3, 36'hFFFFFFFFF, 1'b0, 1'b0, 36'h0,         4'd11}, // R11
    '{1'b1, 1'b1, 4'hF, 4'd0, 36'h0,         1'b0, 1'b1, 36'h0F0F0F1FF, 4'd4},  // R4
    '{1'b0, 1'b0, 4'hF, 4'd4, 36'h0,         1'b0, 1'b0, 36'h0,         4'd6},  // R6
    '{1'b0, 1'b1, 4'hF, 4'd3, 36'h555555555, 1'b0, 1'b0, 36'h0,         4'd5},  // R5
    '{1'b0, 1'b1, 4'hF, 4'd3, 36'h0,         1'b0, 1'b1, 36'h0F0F0F1FF, 4'd5},  // R5
    '{1'b0, 1'b0, 4'h0, 4'd2, 36'h0,         1'b0, 1'b1, 36'h0F0F0F1FF, 4'd2},  // R2
    '{1'b0, 1'b1, 4'hF, 4'd2, 36'h987654321, 1'b0, 1'b0, 36'h0,         4'd11},
    '{1'b0, 1'b1, 4'hF, 4'd3, 36'h0,         1'b0, 1'b1, 36'h987654321, 4'd7},  // R7
    '{1'b0, 1'b1, 4'hF, 4'd3, 36'h0,         1'b1, 1'b0, 36'h0,         4'd9},  // R9
    '{1'b1, 1'b1, 4'hF, 4'd0, 36'h0,         1'b0, 1'b1, 36'h0F0F0F1FF, 4'd8}   // R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic selN = 1'b1, wrN = 1'b1, outEnN = 1'b0, sleep = 1'b0;
  logic [LANES-1:0] laneWrN = '1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lw_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .selN(selN), .wrN(wrN),
    .laneWrN(laneWrN), .dIn(dIn), .outEnN(outEnN), .sleep(sleep),
    .dOut(dOut), .dOe(dOe)
  );

  task automatic chk(input int r, input logic aOe, input logic [DW-1:0] aD,
                     input logic eOe, input logic [DW-1:0] eD, input bit useD);
    checks++;
    if (aOe !== eOe || (useD && aD !== eD)) begin
      fails++;
      $display("FAIL R%0d: dOe=%0b dOut=%h expected dOe=%0b dOut=%h",
               r, aOe, aD, eOe, eD);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(1, dOe, dOut, 1'b0, '0, 1'b1);  // R1 reset state

    for (int k = 0; k < ROWS; k++) begin
      selN = VEC[k].selN; wrN = VEC[k].wrN; laneWrN = VEC[k].lanesN;
      addr = VEC[k].addr; dIn = VEC[k].din; outEnN = VEC[k].oeN;
      @(posedge clk);
      @(negedge clk);
      chk(int'(VEC[k].req), dOe, dOut, VEC[k].expOe, VEC[k].expData, VEC[k].expOe);
    end

    // R10: sleep blocks output at once and ignores a full write plus its data
    sleep = 1'b1; selN = 1'b0; wrN = 1'b0; laneWrN = '0; addr = 4'd3;
    #1 chk(10, dOe, dOut, 1'b0, '0, 1'b0);
    @(posedge clk); @(negedge clk);
    wrN = 1'b1; laneWrN = '1; dIn = 36'h111111111;
    @(posedge clk); @(negedge clk);
    sleep = 1'b0; selN = 1'b0; wrN = 1'b1; addr = 4'd3; dIn = '0;
    @(posedge clk); @(negedge clk);
    selN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(10, dOe, dOut, 1'b1, 36'h0F0F0F1FF, 1'b1);

    // R9: output enable acts without a clock edge
    outEnN = 1'b1;
    #1 chk(9, dOe, dOut, 1'b0, '0, 1'b0);
    outEnN = 1'b0;
    #1 chk(9, dOe, dOut, 1'b1, 36'h0F0F0F1FF, 1'b1);

    finishRun();
  end

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finishRun();
  end
endmodule